// File: doc/BRIEF.md
# Quasi-Uniform LLR Message Quantizer

This block converts decoder messages between two forms. In encode mode a signed fixed-point log-likelihood value is mapped to a compact (Q+1)-bit code. In decode mode such a code is expanded back to a full-width fixed-point value. The code has two regions, selected by one region bit. Near zero the levels are evenly spaced by a fine step. Above that they climb a geometric ladder whose ratio is a compile-time parameter. This keeps fine resolution for small messages and still reaches large magnitudes without clipping early.

Inputs arrive on a valid/ready stream that carries a mode bit and a data word. Results leave on a valid-only stream exactly two clock edges after acceptance, in order. There are two state machines:
- The controller has the states `CTL_HOLD` and `CTL_RUN`. The transition HOLD→RUN is taken on the first edge with reset low. The transition RUN→HOLD is taken on any edge with reset high.
- The stage-1 operation register holds `OP_NONE`, `OP_ENC` or `OP_DEC`. Each edge moves it to ENC or DEC when a beat is accepted with the matching mode. Otherwise it moves to NONE.

The parameters are:
- `Q`: code index width plus one.
- `DW`: data width.
- `STEP`: the fine step, in input LSBs.
- `RATIO_Q4`: the ratio d, with 4 fractional bits.

The size constant is N = 2^(Q-1) − 1.

Top module: `qq_quantizer`

## Requirements
- R1: The code is Q+1 bits wide and sits in the low bits of the data word: bit Q is sign, bit Q-1 is region, bits Q-2:0 are the index. On encode, data bits above Q are zero. in_mode 0 selects encode and 1 selects decode.
- R2: Region-0 code with index i represents magnitude i·STEP. Encode uses i from 0 to N−1 only.
- R3: Region-1 code with index r (1..N) represents magnitude L(r) = (N·STEP·P(r)+8)>>4. Here P(0)=16 and P(r)=(P(r−1)·RATIO_Q4+8)>>4. Region-1 index 0 decodes as L(N).
- R4: Encode selects the level nearest to |input|. An exact midpoint between two levels picks the smaller magnitude.
- R5: Any |input| above the midpoint of the two top levels encodes as region 1, r = N. This includes the most negative input.
- R6: A negative input keeps sign 1 unless it encodes to magnitude zero. Any input that encodes to level zero gives code 0.
- R7: Decode returns the two's-complement signed magnitude. A code with sign 1 and magnitude zero decodes to 0. Region-0 index N decodes to N·STEP. Data bits above Q are ignored on decode.
- R8: Decoding any legal code and then encoding the result returns the same code.
- R9: Each accepted beat yields exactly one output beat two clock edges later, in acceptance order, with no beat dropped.
- R10: While reset is high, in_ready and out_valid are 0. in_ready becomes 1 on the first edge with reset low.
- R11: A cycle with in_valid or in_ready low produces no output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_mode | input | 1 | 0 encode, 1 decode |
| in_data | input | DW | Value to encode, or code in bits Q:0 to decode |
| out_valid | output | 1 | Result beat present |
| out_data | output | DW | Encoded code (zero-extended) or decoded value |

## Verification
The properties assume that reset is held for at least three edges at start-up, so that two-edge look-backs see defined handshake signals. They also assume that the parameters keep L(N) within the signed range of DW bits. The stimulus holds reset for four edges and uses the default parameters, whose top level is 324. Inputs change only on falling edges, so in_mode and in_valid are settled before every rising edge.

// File: rtl/qq_pkg.sv
package qq_pkg;

    typedef enum logic [1:0] {OP_NONE, OP_ENC, OP_DEC} op_e;
    typedef enum logic {CTL_HOLD, CTL_RUN} ctl_e;

    // magnitude of ladder rung r, in input LSBs
    function automatic longint ladder_level(input int n, input int step,
                                            input int ratio_q4, input int r);
        longint p;
        p = 16;
        for (int i = 0; i < r; i++)
            p = (p * longint'(ratio_q4) + 64'sd8) >>> 4;
        return (longint'(n) * longint'(step) * p + 64'sd8) >>> 4;
    endfunction

    // k-th representable magnitude in ascending order (0..2n-1)
    function automatic longint level_at(input int n, input int step,
                                        input int ratio_q4, input int k);
        if (k < n)
            return longint'(k) * longint'(step);
        return ladder_level(n, step, ratio_q4, k - n + 1);
    endfunction

endpackage

// File: rtl/qq_ctrl.sv
module qq_ctrl (
    input  logic clk,
    input  logic rst,
    output logic ready
);
    import qq_pkg::*;

    ctl_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= CTL_HOLD;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CTL_HOLD: state_nx = CTL_RUN;
            CTL_RUN:  state_nx = CTL_RUN;
            default:  state_nx = CTL_HOLD;
        endcase
    end

    always_comb begin
        unique case (state)
            CTL_RUN: ready = 1'b1;
            default: ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/qq_encoder.sv
module qq_encoder #(
    parameter int Q        = 3,
    parameter int DW       = 12,
    parameter int STEP     = 4,
    parameter int RATIO_Q4 = 48
) (
    input  logic [DW-1:0] value,
    output logic [Q:0]    code
);
    import qq_pkg::*;

    localparam int N    = 2**(Q-1) - 1;
    localparam int NLEV = 2 * N;
    localparam int IW   = Q - 1;

    logic          neg;
    logic [DW:0]   mag;
    int            rank;

    always_comb begin
        neg = value[DW-1];
        mag = neg ? (~{value[DW-1], value} + 1'b1) : {value[DW-1], value};
        // count midpoints strictly below |value|: ties stay on the lower level
        rank = 0;
        for (int k = 0; k < NLEV - 1; k++) begin
            if ((longint'(mag) <<< 1) >
                (level_at(N, STEP, RATIO_Q4, k) + level_at(N, STEP, RATIO_Q4, k + 1)))
                rank++;
        end
        if (rank < N)
            code = {neg && (rank != 0), 1'b0, IW'(rank)};
        else
            code = {neg, 1'b1, IW'(rank - N + 1)};
    end

endmodule

// File: rtl/qq_decoder.sv
module qq_decoder #(
    parameter int Q        = 3,
    parameter int DW       = 12,
    parameter int STEP     = 4,
    parameter int RATIO_Q4 = 48
) (
    input  logic [Q:0]    code,
    output logic [DW-1:0] value
);
    import qq_pkg::*;

    localparam int N  = 2**(Q-1) - 1;
    localparam int IW = Q - 1;

    logic [IW-1:0] idx;
    longint        mag;

    always_comb begin
        idx = code[IW-1:0];
        mag = 0;
        if (code[Q-1]) begin
            for (int r = 1; r <= N; r++) begin
                if ((int'(idx) == r) || ((idx == '0) && (r == N)))
                    mag = ladder_level(N, STEP, RATIO_Q4, r);
            end
        end else begin
            mag = longint'(idx) * longint'(STEP);
        end
        value = code[Q] ? DW'(-mag) : DW'(mag);
    end

endmodule

// File: rtl/qq_quantizer.sv
module qq_quantizer #(
    parameter int Q        = 3,
    parameter int DW       = 12,
    parameter int STEP     = 4,
    parameter int RATIO_Q4 = 48
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_mode,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    import qq_pkg::*;

    localparam int CW = Q + 1;

    op_e           s1_op, s1_op_nx;
    logic [DW-1:0] s1_data;
    logic [Q:0]    enc_code;
    logic [DW-1:0] dec_value;
    logic          take;

    qq_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .ready (in_ready)
    );

    assign take = in_valid && in_ready;

    always_comb begin
        unique case ({take, in_mode})
            2'b10:   s1_op_nx = OP_ENC;
            2'b11:   s1_op_nx = OP_DEC;
            default: s1_op_nx = OP_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s1_op <= OP_NONE;
        else     s1_op <= s1_op_nx;
    end

    always_ff @(posedge clk) begin
        if (take) s1_data <= in_data;
    end

    qq_encoder #(.Q(Q), .DW(DW), .STEP(STEP), .RATIO_Q4(RATIO_Q4)) u_enc (
        .value (s1_data),
        .code  (enc_code)
    );

    qq_decoder #(.Q(Q), .DW(DW), .STEP(STEP), .RATIO_Q4(RATIO_Q4)) u_dec (
        .code  (s1_data[Q:0]),
        .value (dec_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            unique case (s1_op)
                OP_ENC: begin
                    out_valid <= 1'b1;
                    out_data  <= {{(DW-CW){1'b0}}, enc_code};
                end
                OP_DEC: begin
                    out_valid <= 1'b1;
                    out_data  <= dec_value;
                end
                default: out_valid <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/qq_quantizer_chk.sv
module qq_quantizer_chk #(
    parameter int Q        = 3,
    parameter int DW       = 12,
    parameter int STEP     = 4,
    parameter int RATIO_Q4 = 48
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_mode,
    input logic [DW-1:0] in_data,
    input logic          out_valid,
    input logic [DW-1:0] out_data
);
    import qq_pkg::*;

    localparam int     N   = 2**(Q-1) - 1;
    localparam longint TOP = ladder_level(N, STEP, RATIO_Q4, N);

    function automatic logic legal_code(input logic [DW-1:0] w);
        logic [Q-2:0] ix;
        ix = w[Q-2:0];
        if (w[Q-1]) return (ix != '0);
        return (int'(ix) <= N - 1) && !(w[Q] && (ix == '0));
    endfunction

    // R10: reset clears both handshake outputs
    p_ready_low_r10: assert property (@(posedge clk) rst |=> !in_ready);
    p_valid_low_r10: assert property (@(posedge clk) rst |=> !out_valid);
    p_ready_up_r10:  assert property (@(posedge clk) disable iff (rst)
                                      (!rst && $past(!rst)) |-> in_ready);
    // R9: accepted beat appears two edges later
    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
                                   $past(in_valid && in_ready, 2) |-> out_valid);
    // R11: no acceptance, no output
    p_no_phantom_r11: assert property (@(posedge clk) disable iff (rst)
                                       !$past(in_valid && in_ready, 2) |-> !out_valid);
    // R1: encode results are legal codes with clean upper bits
    p_code_legal_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(in_mode, 2)) |->
        (legal_code(out_data) && ((out_data >> (Q + 1)) == '0)));
    // R6: zero encodes to code 0
    p_zero_pos_r6: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && in_ready && !in_mode && (in_data == '0), 2) |-> (out_data == '0));
    // R7: decoded magnitudes never exceed the top rung
    p_dec_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_mode, 2)) |->
        ((longint'($signed(out_data)) <= TOP) && (longint'($signed(out_data)) >= -TOP)));

endmodule

bind qq_quantizer qq_quantizer_chk #(.Q(Q), .DW(DW), .STEP(STEP), .RATIO_Q4(RATIO_Q4)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_mode(in_mode),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_qq_quantizer.sv
module test_qq_quantizer;
    localparam int PERIOD   = 10;
    localparam int Q        = 3;
    localparam int DW       = 12;
    localparam int STEP     = 4;
    localparam int RATIO_Q4 = 48;
    localparam int N        = 2**(Q-1) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_mode = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic          prev_v = 1'b0;
    logic [DW-1:0] prev_d = '0;
    string         prev_tag = "";
    logic [DW-1:0] cap[$];

    qq_quantizer #(.Q(Q), .DW(DW), .STEP(STEP), .RATIO_Q4(RATIO_Q4)) i_qq_quantizer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_mode(in_mode),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic int lvl(int k);
        int p;
        if (k < N) return k * STEP;
        p = 16;
        for (int i = 0; i < k - N + 1; i++) p = (p * RATIO_Q4 + 8) / 16;
        return (N * STEP * p + 8) / 16;
    endfunction

    function automatic logic [DW-1:0] model_enc(int x);
        int m, best, bd, dd;
        m = (x < 0) ? -x : x;
        best = 0;
        bd = m;
        for (int k = 1; k < 2 * N; k++) begin
            dd = (m > lvl(k)) ? m - lvl(k) : lvl(k) - m;
            if (dd < bd) begin best = k; bd = dd; end
        end
        if (best == 0) return '0;
        if (best < N) return DW'(((x < 0) ? 8 : 0) + best);
        return DW'(((x < 0) ? 8 : 0) + 4 + (best - N + 1));
    endfunction

    function automatic logic [DW-1:0] model_dec(int code);
        int mag, ix;
        ix = code % 4;
        if ((code / 4) % 2 == 1) mag = lvl(N - 1 + ((ix == 0) ? N : ix));
        else mag = ix * STEP;
        return ((code / 8) % 2 == 1) ? DW'(-mag) : DW'(mag);
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one clock: present inputs at falling edge, compare outputs at the next falling edge
    task automatic step(input logic v, input logic m, input logic [DW-1:0] d, input string tag);
        logic acc;
        logic [DW-1:0] e;
        in_valid = v; in_mode = m; in_data = d;
        acc = v && in_ready;
        e = m ? model_dec(int'(d[Q:0])) : model_enc(int'($signed(d)));
        @(posedge clk);
        @(negedge clk);
        check(out_valid == prev_v, {prev_tag, " out_valid (R9 R11)"}, int'(out_valid), int'(prev_v));
        if (prev_v && out_valid) begin
            check(out_data == prev_d, prev_tag, int'($signed(out_data)), int'($signed(prev_d)));
            cap.push_back(out_data);
        end
        prev_v = acc;
        prev_d = e;
        prev_tag = tag;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            summary();
        end
    end

    initial begin
        int legal[$];
        repeat (4) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R10 ready in reset", int'(in_ready), 0);
            check(out_valid == 1'b0, "R10 valid in reset", int'(out_valid), 0);
        end
        rst = 1'b0;
        check(in_ready == 1'b0, "R10 ready before first edge", int'(in_ready), 0);
        // R11: valid offered while not ready must not be accepted
        step(1'b1, 1'b0, DW'(100), "R11");
        check(in_ready == 1'b1, "R10 ready after first edge", int'(in_ready), 1);
        step(1'b0, 1'b0, DW'(200), "R11");

        // R4 R5 R6 encode sweep with gaps, including midpoints 2,6,22,72,216
        for (int x = -700; x <= 700; x++) begin
            if ($urandom % 4 == 0) step(1'b0, 1'b0, DW'(x), "R11 idle");
            step(1'b1, 1'b0, DW'(x), "R4 encode");
        end
        step(1'b1, 1'b0, DW'(-2048), "R5 most negative");
        step(1'b1, 1'b0, DW'(2047), "R5 most positive");
        step(1'b1, 1'b0, DW'(0), "R6 zero");
        step(1'b1, 1'b0, DW'(-1), "R6 small negative");

        // R2 R3 R7 all codes decoded, with junk in upper data bits
        for (int c = 0; c < 16; c++)
            step(1'b1, 1'b1, DW'(c) | DW'(12'hA50), "R7 decode");
        step(1'b0, 1'b0, '0, "drain");
        step(1'b0, 1'b0, '0, "drain");

        // R8 round trip: decode each legal code, then encode the result
        for (int c = 0; c < 16; c++) begin
            if ((c / 4) % 2 == 1) begin
                if (c % 4 != 0) legal.push_back(c);
            end else if (c % 4 <= N - 1 && !(c == 8)) legal.push_back(c);
        end
        cap.delete();
        foreach (legal[i]) step(1'b1, 1'b1, DW'(legal[i]), "R8 decode");
        step(1'b0, 1'b0, '0, "drain");
        step(1'b0, 1'b0, '0, "drain");
        begin
            logic [DW-1:0] vals[$];
            vals = cap;
            cap.delete();
            foreach (vals[i]) step(1'b1, 1'b0, vals[i], "R8 encode");
            step(1'b0, 1'b0, '0, "drain");
            step(1'b0, 1'b0, '0, "drain");
            check(cap.size() == legal.size(), "R8 count", cap.size(), legal.size());
            foreach (legal[i])
                if (i < cap.size())
                    check(int'(cap[i]) == legal[i], "R8 round trip", int'(cap[i]), legal[i]);
        end
        // R1 layout spot checks: -324 -> sign|region|3, 36 -> region|1
        cap.delete();
        step(1'b1, 1'b0, DW'(-324), "R1 layout");
        step(1'b1, 1'b0, DW'(36), "R1 layout");
        step(1'b0, 1'b0, '0, "drain");
        step(1'b0, 1'b0, '0, "drain");
        check(cap.size() == 2 && cap[0] == DW'(15), "R1 code -324", cap.size() > 0 ? int'(cap[0]) : -1, 15);
        check(cap.size() == 2 && cap[1] == DW'(5), "R1 code 36", cap.size() > 1 ? int'(cap[1]) : -1, 5);
        // R3 R2 decode spot values
        check(model_dec(6) == DW'(108), "R3 rung 2", int'(model_dec(6)), 108);
        done = 1'b1;
        summary();
    end

endmodule